// File: doc/BRIEF.md
# USB device endpoint configuration and data-toggle manager

This block keeps the per-endpoint state of a USB device controller: for each endpoint number and each direction it holds an enable, a transfer type, a stall flag, a toggle-inhibit flag and the current data toggle. Software reaches it through a simple register port with one 32-bit control word per endpoint number. The OUT (receive) direction sits in the low half of the word and the IN (transmit) direction sits in the high half, so the two directions of one number can be configured with different types.

The packet engine presents each token to the block on the transaction port. The block answers in the same cycle with the data PID it expects (DATA0 or DATA1) and the handshake to use. When the engine reports that the transaction completed, the block moves the toggle on, or handles a SETUP token on a control endpoint. Endpoint 0 is always an enabled control endpoint.

Top module: `usb_ep_ctrl`

## Requirements
- R1: After reset, endpoint 0 has both directions enabled as control type. Every other endpoint is disabled with type 00. All toggles read DATA0 and all stall and inhibit flags read 0.
- R2: Each 16-bit half of a control word uses this layout. Bit 0 is stall. Bits 3:2 are the type: 00 control, 01 isochronous, 10 bulk, 11 interrupt. Bit 5 is toggle inhibit, bit 6 is toggle reset (write only), bit 7 is enable, and bit 8 is the current toggle (read only, 1 = DATA1). Bits 15:0 are the OUT direction and bits 31:16 are the IN direction. Each direction takes its own values. Every bit not named here reads 0.
- R3: Writes to endpoint 0 cannot change its enable or type bits. Both directions always read back as enabled control endpoints.
- R4: Writing 1 to a direction's toggle-reset bit sets that direction's toggle to DATA0. The bit always reads 0. A register write to an endpoint takes priority over a transaction update to that endpoint in the same cycle.
- R5: The handshake output is coded 00 none, 01 ACK, 10 NAK, 11 STALL. With no valid token it is none. Otherwise the first matching rule applies, in this order:
  - disabled direction gives none;
  - SETUP gives ACK on an enabled control OUT direction, and none anywhere else;
  - stall set gives STALL;
  - isochronous type gives none;
  - busy gives NAK;
  - anything else gives ACK.
- R6: The expected PID output is 0 (DATA0) for isochronous directions and SETUP tokens. Otherwise it equals the direction's toggle.
- R7: A completed non-SETUP transaction whose handshake is ACK flips that direction's toggle. NAK, STALL and none leave it unchanged.
- R8: While a direction's inhibit bit is set, its toggle does not advance.
- R9: A completed SETUP acknowledged on a control endpoint clears the stall bits of both directions, sets the IN toggle to DATA1 and sets the OUT toggle to DATA0.
- R10: Bit 15 of the read word is 1 when either direction has control type and the two halves differ in enable, type or inhibit.
- R11: A token to a disabled direction, even when completed, leaves all toggle state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Endpoint number for read and write |
| reg_wdata | input | 32 | Control word to write |
| reg_rdata | output | 32 | Control word of the addressed endpoint |
| tx_valid | input | 1 | Token presented |
| tx_ep | input | AW | Token endpoint number |
| tx_dir | input | 1 | 1 = IN, 0 = OUT |
| tx_setup | input | 1 | Token is SETUP |
| tx_busy | input | 1 | Data buffer not ready |
| tx_done | input | 1 | Transaction completed this cycle |
| exp_pid | output | 1 | Expected data PID, 1 = DATA1 |
| hs | output | 2 | Handshake decision |

## Verification
The bench builds the block with the default of four endpoint numbers. With that setting, every endpoint address and both directions of each can be driven directly, including endpoint 0 with its fixed settings and the disabled endpoints left over after reset. Random control words and tokens then mix every type, stall, inhibit and busy combination on all eight directions. This lets write-versus-transaction collisions on the same endpoint and SETUP handling on control numbers other than 0 occur.

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl #(
  parameter int NUM_EP = 4,
  localparam int AW = $clog2(NUM_EP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          tx_valid,
  input  logic [AW-1:0] tx_ep,
  input  logic          tx_dir,
  input  logic          tx_setup,
  input  logic          tx_busy,
  input  logic          tx_done,
  output logic          exp_pid,
  output logic [1:0]    hs
);
  localparam logic [1:0] HS_NONE = 2'd0, HS_ACK = 2'd1, HS_NAK = 2'd2, HS_STALL = 2'd3;
  localparam logic [1:0] T_CTRL = 2'd0, T_ISO = 2'd1;

  logic [1:0][NUM_EP-1:0]      en_q, stl_q, inh_q, tog_q;
  logic [1:0][NUM_EP-1:0][1:0] typ_q;

  logic       s_en, s_stl, s_inh, s_tog;
  logic [1:0] s_typ;
  assign s_en  = en_q[tx_dir][tx_ep];
  assign s_stl = stl_q[tx_dir][tx_ep];
  assign s_inh = inh_q[tx_dir][tx_ep];
  assign s_tog = tog_q[tx_dir][tx_ep];
  assign s_typ = typ_q[tx_dir][tx_ep];

  always_comb begin
    if (!tx_valid || !s_en)  hs = HS_NONE;
    else if (tx_setup)       hs = (!tx_dir && s_typ == T_CTRL) ? HS_ACK : HS_NONE;
    else if (s_stl)          hs = HS_STALL;
    else if (s_typ == T_ISO) hs = HS_NONE;
    else if (tx_busy)        hs = HS_NAK;
    else                     hs = HS_ACK;
  end

  assign exp_pid = (tx_setup || s_typ == T_ISO) ? 1'b0 : s_tog;

  logic ack_done, setup_hit, adv;
  assign ack_done  = tx_valid && tx_done && hs == HS_ACK;
  assign setup_hit = ack_done && tx_setup;
  assign adv       = ack_done && !tx_setup && !s_inh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      en_q[0][0] <= 1'b1;
      en_q[1][0] <= 1'b1;
      stl_q <= '0;
      inh_q <= '0;
      tog_q <= '0;
      typ_q <= '0;
    end else begin
      for (int i = 0; i < NUM_EP; i++) begin
        for (int d = 0; d < 2; d++) begin
          if (reg_we && reg_addr == AW'(i)) begin
            stl_q[d][i] <= reg_wdata[16*d];
            inh_q[d][i] <= reg_wdata[16*d+5];
            if (i != 0) begin
              en_q[d][i]  <= reg_wdata[16*d+7];
              typ_q[d][i] <= reg_wdata[16*d+2 +: 2];
            end
            if (reg_wdata[16*d+6]) tog_q[d][i] <= 1'b0;
          end else if (setup_hit && tx_ep == AW'(i)) begin
            stl_q[d][i] <= 1'b0;
            tog_q[d][i] <= (d == 1);
          end else if (adv && tx_ep == AW'(i) && tx_dir == d[0]) begin
            tog_q[d][i] <= ~tog_q[d][i];
          end
        end
      end
    end
  end

  logic [1:0][15:0] half;
  logic             mism;
  always_comb begin
    for (int d = 0; d < 2; d++)
      half[d] = {7'd0, tog_q[d][reg_addr], en_q[d][reg_addr], 1'b0, inh_q[d][reg_addr],
                 1'b0, typ_q[d][reg_addr], 1'b0, stl_q[d][reg_addr]};
    mism = (typ_q[0][reg_addr] == T_CTRL || typ_q[1][reg_addr] == T_CTRL) &&
           (en_q[0][reg_addr] != en_q[1][reg_addr] || typ_q[0][reg_addr] != typ_q[1][reg_addr] ||
            inh_q[0][reg_addr] != inh_q[1][reg_addr]);
    reg_rdata = {half[1], mism, half[0][14:0]};
  end
endmodule

module usb_ep_ctrl_chk #(
  parameter int NUM_EP = 4,
  localparam int AW = $clog2(NUM_EP)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_rdata,
  input logic          tx_valid,
  input logic [AW-1:0] tx_ep,
  input logic          tx_setup,
  input logic          tx_done,
  input logic          exp_pid,
  input logic [1:0]    hs
);
  assert_idle_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> hs == 2'd0);
  assert_setup_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_setup) |-> hs != 2'd3);
  assert_setup_data0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_setup) |-> !exp_pid);
  assert_rst_bit_reads0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6] |-> 1'b0);
  assert_rst_bit_in_reads0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[22] |-> 1'b0);
  assert_ep0_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == '0 |-> (reg_rdata[7] && reg_rdata[23] && reg_rdata[3:2] == 2'd0 && reg_rdata[19:18] == 2'd0));
  assert_setup_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_setup && tx_done && hs == 2'd1 && !reg_we) |=>
      (!$stable(reg_addr) || reg_addr != $past(tx_ep) ||
       (reg_rdata[24] && !reg_rdata[8] && !reg_rdata[0] && !reg_rdata[16])));
endmodule

bind usb_ep_ctrl usb_ep_ctrl_chk #(.NUM_EP(NUM_EP)) i_chk (.*);

// File: tb/test_usb_ep_ctrl.sv
module test_usb_ep_ctrl;
  localparam int N = 4;
  localparam int AW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, tx_valid = 0, tx_dir = 0, tx_setup = 0, tx_busy = 0, tx_done = 0;
  logic [AW-1:0] reg_addr = '0, tx_ep = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic exp_pid;
  logic [1:0] hs;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  usb_ep_ctrl #(.NUM_EP(N)) i_usb_ep_ctrl (.*);

  bit       m_en[2][N], m_stl[2][N], m_inh[2][N], m_tog[2][N];
  bit [1:0] m_typ[2][N];

  function automatic bit [1:0] f_hs(bit v, int ep, bit d, bit s, bit b);
    if (!v || !m_en[d][ep]) return 2'd0;
    if (s) return (!d && m_typ[d][ep] == 2'd0) ? 2'd1 : 2'd0;
    if (m_stl[d][ep]) return 2'd3;
    if (m_typ[d][ep] == 2'd1) return 2'd0;
    if (b) return 2'd2;
    return 2'd1;
  endfunction

  function automatic bit f_pid(int ep, bit d, bit s);
    return (s || m_typ[d][ep] == 2'd1) ? 1'b0 : m_tog[d][ep];
  endfunction

  function automatic bit [31:0] f_rd(int a);
    bit [31:0] r = '0;
    for (int d = 0; d < 2; d++) begin
      r[16*d]       = m_stl[d][a];
      r[16*d+2 +: 2] = m_typ[d][a];
      r[16*d+5]     = m_inh[d][a];
      r[16*d+7]     = m_en[d][a];
      r[16*d+8]     = m_tog[d][a];
    end
    r[15] = (m_typ[0][a] == 2'd0 || m_typ[1][a] == 2'd0) &&
            (m_en[0][a] != m_en[1][a] || m_typ[0][a] != m_typ[1][a] || m_inh[0][a] != m_inh[1][a]);
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit we, int a, bit [31:0] wd,
                     bit v, int ep, bit d, bit s, bit b, bit dn);
    bit [1:0] h;
    @(negedge clk);
    reg_we = we; reg_addr = AW'(a); reg_wdata = wd;
    tx_valid = v; tx_ep = AW'(ep); tx_dir = d; tx_setup = s; tx_busy = b; tx_done = dn;
    #1;
    h = f_hs(v, ep, d, s, b);
    chk({tag, " R5 hs"}, {30'd0, hs}, {30'd0, h});
    if (v) chk({tag, " R6 pid"}, {31'd0, exp_pid}, {31'd0, f_pid(ep, d, s)});
    chk({tag, " R2 rdata"}, reg_rdata, f_rd(a));
    @(posedge clk);
    if (v && dn && h == 2'd1 && !(we && a == ep)) begin
      if (s) begin
        m_stl[0][ep] = 0; m_stl[1][ep] = 0; m_tog[1][ep] = 1; m_tog[0][ep] = 0;
      end else if (!m_inh[d][ep]) m_tog[d][ep] = ~m_tog[d][ep];
    end
    if (we) for (int k = 0; k < 2; k++) begin
      m_stl[k][a] = wd[16*k];
      m_inh[k][a] = wd[16*k+5];
      if (a != 0) begin m_en[k][a] = wd[16*k+7]; m_typ[k][a] = wd[16*k+2 +: 2]; end
      if (wd[16*k+6]) m_tog[k][a] = 0;
    end
  endtask

  task automatic rd(string tag, int a);
    cyc(tag, 0, a, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++)
      for (int e = 0; e < N; e++) begin
        m_en[d][e] = (e == 0); m_stl[d][e] = 0; m_inh[d][e] = 0; m_tog[d][e] = 0; m_typ[d][e] = 0;
      end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int e = 0; e < N; e++) rd("R1 reset", e);
    cyc("R3 ep0 write", 1, 0, 32'h0004_0004, 0, 0, 0, 0, 0, 0);
    rd("R3 ep0 read", 0);
    cyc("R2 ep1 bulk/int", 1, 1, 32'h008C_0088, 0, 0, 0, 0, 0, 0);
    rd("R2 ep1 read", 1);
    cyc("R10 ep2 ctrl/bulk", 1, 2, 32'h0088_0080, 0, 0, 0, 0, 0, 0);
    rd("R10 ep2 read", 2);
    cyc("R7 ep1 in ack", 0, 1, 0, 1, 1, 1, 0, 0, 1);
    cyc("R7 ep1 in ack2", 0, 1, 0, 1, 1, 1, 0, 0, 1);
    cyc("R7 ep1 in nak", 0, 1, 0, 1, 1, 1, 0, 1, 1);
    cyc("R7 ep1 out ack", 0, 1, 0, 1, 1, 0, 0, 0, 1);
    rd("R7 ep1 read", 1);
    cyc("R8 ep1 out inhibit", 1, 1, 32'h008C_00A8, 0, 0, 0, 0, 0, 0);
    cyc("R8 ep1 out ack", 0, 1, 0, 1, 1, 0, 0, 0, 1);
    rd("R8 ep1 read", 1);
    cyc("R4 ep1 toggle reset", 1, 1, 32'h00CC_00C8, 0, 0, 0, 0, 0, 0);
    rd("R4 ep1 read", 1);
    cyc("R4 write wins", 1, 1, 32'h008C_0088, 1, 1, 1, 0, 0, 1);
    rd("R4 collision read", 1);
    cyc("R9 stall ep0", 1, 0, 32'h0001_0001, 0, 0, 0, 0, 0, 0);
    cyc("R9 ep0 stalled", 0, 0, 0, 1, 0, 1, 0, 0, 1);
    cyc("R9 setup", 0, 0, 0, 1, 0, 0, 1, 0, 1);
    rd("R9 ep0 read", 0);
    cyc("R9 setup on IN", 0, 0, 0, 1, 0, 1, 1, 0, 1);
    cyc("R11 ep3 disabled", 0, 3, 0, 1, 3, 1, 0, 0, 1);
    rd("R11 ep3 read", 3);
    cyc("R6 ep3 iso", 1, 3, 32'h0084_0084, 0, 0, 0, 0, 0, 0);
    cyc("R6 ep3 iso in", 0, 3, 0, 1, 3, 1, 0, 0, 1);
    rd("R6 ep3 read", 3);
    for (int i = 0; i < 3000; i++) begin
      bit [31:0] w = $urandom;
      bit we = ($urandom % 5) == 0;
      w[0]  = ($urandom % 4) == 0;
      w[16] = ($urandom % 4) == 0;
      w[7]  = ($urandom % 4) != 0;
      w[23] = ($urandom % 4) != 0;
      w[6]  = ($urandom % 6) == 0;
      w[22] = ($urandom % 6) == 0;
      cyc("R7 random", we, int'($urandom % N), w, ($urandom % 4) != 0, int'($urandom % N),
          1'($urandom), ($urandom % 8) == 0, ($urandom % 5) == 0, ($urandom % 3) != 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule